// File: doc/BRIEF.md
# Multiply and multiply-accumulate unit

This unit performs the multiply instructions of a small CPU core. On a one-cycle `start` strobe it captures an operation code, two 16-bit register-pair operands, the current 32-bit accumulator value and the current status byte. A fixed number of clocks later, set per operation class, it presents the 32-bit product split into high and low words, the updated accumulator and the updated status byte, and marks them with a one-cycle `done` pulse.

Five operations exist. The byte multiply takes the upper and lower bytes of the first operand. Two 16x16 multiplies, one signed and one unsigned, give a 32-bit product. Two 16x16 multiply-accumulates, one signed and one unsigned, add the product into the accumulator with 32-bit wraparound. Only the accumulate forms change the carry and auxiliary-carry bits of the status byte. The caller's register file writes back the results and holds the accumulator.

Top module: `mac_unit`

## Requirements
- R1: After reset `busy`, `done`, `res_hi`, `res_lo`, `acc_out` and `psw_out` are all zero.
- R2: Op code 0 (byte multiply) gives `res_lo` = `opnd_a[15:8]` * `opnd_a[7:0]` unsigned, with `res_hi` = 0.
- R3: Op code 1 (signed multiply) gives `{res_hi,res_lo}` = the two's-complement product of `opnd_a` and `opnd_b`.
- R4: Op code 2 (unsigned multiply) gives `{res_hi,res_lo}` = the unsigned product of `opnd_a` and `opnd_b`.
- R5: Op code 3 (signed accumulate) gives `acc_out` = (`acc_in` + signed product) mod 2^32. For op codes 3 and 4, `{res_hi,res_lo}` also carries the product.
- R6: For op code 3, status bit 0 (carry) is set exactly when bit 31 of the accumulator differs between `acc_in` and `acc_out`, and status bit 4 (auxiliary carry) equals bit 31 of `acc_out`.
- R7: Op code 4 (unsigned accumulate) gives `acc_out` = (`acc_in` + unsigned product) mod 2^32. Carry is set exactly when `acc_out` < `acc_in`, and auxiliary carry is cleared.
- R8: `done` is a one-cycle pulse that rises 1 clock after the start edge for op 0, 2 clocks after it for ops 1 and 2, and 3 clocks after it for ops 3 and 4. All results are valid while it is high.
- R9: Status bits other than bits 0 and 4 pass from `psw_in` to `psw_out` unchanged.
- R10: For ops 0 to 2, `acc_out` equals the captured `acc_in` and `psw_out` equals the captured `psw_in`.
- R11: `busy` is high from the accepted start until `done`. A `start` seen while busy is ignored: it produces no extra `done` and does not change the pending results.
- R12: Op codes 5 to 7 are ignored. They raise neither `busy` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation this cycle |
| op | input | 3 | Operation code (0..4 valid) |
| opnd_a | input | 16 | First register-pair operand |
| opnd_b | input | 16 | Second register-pair operand |
| acc_in | input | 32 | Current accumulator value |
| psw_in | input | 8 | Current status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 16 | Upper half of product |
| res_lo | output | 16 | Lower half of product |
| acc_out | output | 32 | Updated accumulator |
| psw_out | output | 8 | Updated status byte |

## Verification
The bench builds the unit with its defaults: 16-bit operands and latencies of 1, 2 and 3 clocks. Because each class has a different latency, every class lands on its own completion cycle. The 16-bit width puts the sign boundary at bit 31 and the unsigned wrap at 2^32, so the bench can drive carry and auxiliary-carry to both values with small operands and edge accumulators. The bench also sends a second start while busy and sends reserved op codes, and the scoreboard catches any `done` that arrives without an expected item.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL8  = 3'd0,
        OP_MULS  = 3'd1,
        OP_MULU  = 3'd2,
        OP_MACS  = 3'd3,
        OP_MACU  = 3'd4
    } mac_op_e;

    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_is_acc(input logic [2:0] code);
        return (code == OP_MACS) || (code == OP_MACU);
    endfunction

    function automatic logic op_is_signed(input logic [2:0] code);
        return (code == OP_MULS) || (code == OP_MACS);
    endfunction

endpackage

// File: rtl/mac_mul_core.sv
module mac_mul_core #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           byte_mode,
    input  logic           signed_mode,
    output logic [2*W-1:0] prod
);
    localparam int HW = W / 2;
    localparam int PW = 2 * W;

    logic [PW-1:0] ext_a, ext_b, prod_u, corr;

    always_comb begin
        if (byte_mode) begin
            ext_a = {{(W + HW){1'b0}}, a[W-1:HW]};
            ext_b = {{(W + HW){1'b0}}, a[HW-1:0]};
        end else begin
            ext_a = {{W{1'b0}}, a};
            ext_b = {{W{1'b0}}, b};
        end
        prod_u = ext_a * ext_b;
        // two's-complement correction: subtract the weighted opposite operand per negative sign bit
        corr = '0;
        if (signed_mode && !byte_mode) begin
            if (a[W-1]) corr = corr + {b, {W{1'b0}}};
            if (b[W-1]) corr = corr + {a, {W{1'b0}}};
        end
        prod = prod_u - corr;
    end
endmodule

// File: rtl/mac_flag_unit.sv
module mac_flag_unit #(
    parameter int AW     = 32,
    parameter int CY_BIT = 0,
    parameter int AC_BIT = 4
) (
    input  logic [AW-1:0] acc_old,
    input  logic [AW-1:0] acc_new,
    input  logic          signed_mode,
    input  logic [7:0]    psw_old,
    output logic [7:0]    psw_new
);
    logic cy_d, ac_d;

    always_comb begin
        if (signed_mode) begin
            cy_d = acc_old[AW-1] ^ acc_new[AW-1];
            ac_d = acc_new[AW-1];
        end else begin
            cy_d = acc_new < acc_old;
            ac_d = 1'b0;
        end
        psw_new = psw_old;
        psw_new[CY_BIT] = cy_d;
        psw_new[AC_BIT] = ac_d;
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int W         = 16,
    parameter int LAT_BYTE  = 1,
    parameter int LAT_MUL   = 2,
    parameter int LAT_MAC   = 3,
    parameter int CY_BIT    = 0,
    parameter int AC_BIT    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [2*W-1:0]   acc_in,
    input  logic [7:0]       psw_in,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     res_hi,
    output logic [W-1:0]     res_lo,
    output logic [2*W-1:0]   acc_out,
    output logic [7:0]       psw_out
);
    localparam int AW      = 2 * W;
    localparam int LAT_MX1 = (LAT_BYTE > LAT_MUL) ? LAT_BYTE : LAT_MUL;
    localparam int LAT_MAX = (LAT_MX1 > LAT_MAC) ? LAT_MX1 : LAT_MAC;
    localparam int CW      = $clog2(LAT_MAX + 1);
    localparam logic [7:0] FLAG_MASK = (8'h01 << CY_BIT) | (8'h01 << AC_BIT);

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [2:0]      op;
        logic [W-1:0]    a;
        logic [W-1:0]    b;
        logic [AW-1:0]   acc;
        logic [7:0]      psw;
        logic            done;
        logic [W-1:0]    hi;
        logic [W-1:0]    lo;
        logic [AW-1:0]   acc_o;
        logic [7:0]      psw_o;
    } state_t;

    state_t q, d;

    logic [AW-1:0] prod_w, acc_sum;
    logic [7:0]    psw_flag;

    mac_mul_core #(.W(W)) u_core (
        .a           (q.a),
        .b           (q.b),
        .byte_mode   (q.op == OP_MUL8),
        .signed_mode (op_is_signed(q.op)),
        .prod        (prod_w)
    );

    assign acc_sum = q.acc + prod_w;

    mac_flag_unit #(.AW(AW), .CY_BIT(CY_BIT), .AC_BIT(AC_BIT)) u_flags (
        .acc_old     (q.acc),
        .acc_new     (acc_sum),
        .signed_mode (q.op == OP_MACS),
        .psw_old     (q.psw),
        .psw_new     (psw_flag)
    );

    function automatic logic [CW-1:0] lat_of(input logic [2:0] code);
        if (code == OP_MUL8)      return CW'(LAT_BYTE);
        else if (op_is_acc(code)) return CW'(LAT_MAC);
        else                      return CW'(LAT_MUL);
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.hi   = prod_w[AW-1:W];
                d.lo   = prod_w[W-1:0];
                if (op_is_acc(q.op)) begin
                    d.acc_o = acc_sum;
                    d.psw_o = psw_flag;
                end else begin
                    d.acc_o = q.acc;
                    d.psw_o = q.psw;
                end
            end
        end else if (start && op_is_valid(op)) begin
            d.busy = 1'b1;
            d.cnt  = lat_of(op);
            d.op   = op;
            d.a    = opnd_a;
            d.b    = opnd_b;
            d.acc  = acc_in;
            d.psw  = psw_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign res_hi  = q.hi;
    assign res_lo  = q.lo;
    assign acc_out = q.acc_o;
    assign psw_out = q.psw_o;

    // assertions
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r11_inputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(q.a) && $stable(q.b) && $stable(q.op)));
    a_r12_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op_is_valid(op)) |=> !busy);
    a_r7_unsigned_ac_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op == OP_MACU) |-> !psw_out[AC_BIT]);
    a_r9_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((psw_out & ~FLAG_MASK) == (q.psw & ~FLAG_MASK)));
    a_r10_plain_mul_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_is_acc(q.op)) |-> (acc_out == q.acc && psw_out == q.psw));
    a_r6_signed_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op == OP_MACS) |-> (psw_out[CY_BIT] == (acc_out[AW-1] != q.acc[AW-1])));
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] acc_in = '0;
    logic [7:0]  psw_in = '0;
    logic        busy, done;
    logic [15:0] res_hi, res_lo;
    logic [31:0] acc_out;
    logic [7:0]  psw_out;

    always #2.5 clk = ~clk;

    mac_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in), .psw_in(psw_in),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .acc_out(acc_out), .psw_out(psw_out)
    );

    typedef struct {
        int          due;
        logic [31:0] prod;
        logic [31:0] acc;
        logic [7:0]  psw;
        string       tag;
    } exp_t;

    exp_t scb[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (scb.size() == 0) begin
                check("R11/R12 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = scb.pop_front();
                check({e.tag, " R8 cycle"}, 64'(cyc), 64'(e.due));
                check({e.tag, " product"}, {32'd0, res_hi, res_lo}, {32'd0, e.prod});
                check({e.tag, " acc R10"}, {32'd0, acc_out}, {32'd0, e.acc});
                check({e.tag, " psw R9"}, {56'd0, psw_out}, {56'd0, e.psw});
            end
        end
    end

    task automatic issue(input string tag, input logic [2:0] code, input logic [15:0] a,
                         input logic [15:0] b, input logic [31:0] acc, input logic [7:0] psw);
        exp_t e;
        longint p;
        logic [31:0] nacc;
        int lat;
        @(negedge clk);
        case (code)
            3'd0: p = longint'(a[15:8]) * longint'(a[7:0]);
            3'd1, 3'd3: p = longint'($signed(a)) * longint'($signed(b));
            default: p = longint'(a) * longint'(b);
        endcase
        lat = (code == 3'd0) ? 1 : (code <= 3'd2) ? 2 : 3;
        e.prod = p[31:0];
        e.acc = acc;
        e.psw = psw;
        if (code >= 3'd3) begin
            nacc = acc + p[31:0];
            e.acc = nacc;
            e.psw = psw & 8'hEE;
            if (code == 3'd3) begin
                e.psw[0] = nacc[31] != acc[31];
                e.psw[4] = nacc[31];
            end else begin
                e.psw[0] = nacc < acc;
            end
        end
        e.due = cyc + 1 + lat;
        e.tag = tag;
        scb.push_back(e);
        start = 1'b1; op = code; opnd_a = a; opnd_b = b; acc_in = acc; psw_in = psw;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {busy, done, res_hi, res_lo}, 34'd0);
        check("R1 reset acc/psw", {acc_out, psw_out}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue("R2 byte 12x34", 3'd0, 16'h1234, 16'hFFFF, 32'hCAFE0001, 8'hA5);
        issue("R2 byte FFxFF", 3'd0, 16'hFFFF, 16'h0000, 32'h0, 8'h00);
        issue("R3 signed neg*pos", 3'd1, 16'hFFFE, 16'h0003, 32'h1234_5678, 8'h11);
        issue("R3 signed min*min", 3'd1, 16'h8000, 16'h8000, 32'h0, 8'h00);
        issue("R4 unsigned max", 3'd2, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 8'h5A);
        issue("R5 signed acc add", 3'd3, 16'hFFFF, 16'h0002, 32'h0000_0010, 8'h00);
        issue("R6 signed acc sign flip", 3'd3, 16'h0001, 16'h0001, 32'h7FFF_FFFF, 8'h00);
        issue("R6 signed acc back", 3'd3, 16'hFFFF, 16'h0001, 32'h8000_0000, 8'hFF);
        issue("R7 unsigned acc wrap", 3'd4, 16'h0001, 16'h0001, 32'hFFFF_FFFF, 8'h10);
        issue("R7 unsigned acc nowrap", 3'd4, 16'h0100, 16'h0100, 32'h0000_0001, 8'hFF);
        issue("R9 psw other bits", 3'd4, 16'h0002, 16'h0003, 32'h0, 8'hC6);

        // R11: start while busy is ignored
        begin
            exp_t e;
            @(negedge clk);
            e.due = cyc + 3; e.prod = 32'h0000_0006; e.acc = 32'h77; e.psw = 8'h22;
            e.tag = "R11 first op";
            scb.push_back(e);
            start = 1'b1; op = 3'd2; opnd_a = 16'd2; opnd_b = 16'd3; acc_in = 32'h77; psw_in = 8'h22;
            @(negedge clk);
            check("R11 busy", {63'd0, busy}, 64'd1);
            op = 3'd0; opnd_a = 16'hFFFF; acc_in = 32'h0; psw_in = 8'h00;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            check("R11 scoreboard drained", 64'(scb.size()), 64'd0);
        end

        // R12: reserved op codes
        for (int c = 5; c < 8; c++) begin
            start = 1'b1; op = 3'(c);
            @(negedge clk);
            start = 1'b0;
            check("R12 no busy", {63'd0, busy}, 64'd0);
            repeat (4) @(negedge clk);
        end
        check("R12 no pending", 64'(scb.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule